// File: doc/BRIEF.md
# Software Flow-Control Character Detector

This block sits in a serial receiver between the byte deserializer and the receive FIFO. It looks at each received byte and compares it with four programmable characters: two resume codes (`XON_A`, `XON_B`) and two stop codes (`XOFF_A`, `XOFF_B`). Depending on a 2-bit receive compare mode, it recognises a single resume or stop character, or a two-byte sequence. A recognised stop sequence pauses the local transmitter and raises a sticky interrupt flag. A recognised resume sequence lets the transmitter run again. A separate special-character check compares every byte with `XOFF_B` and flags each match.

Bytes enter on a valid/ready stream (`in_*`) and leave on a valid/ready stream (`out_*`) toward the FIFO. The byte path holds no register, so each byte is either forwarded in the same cycle or swallowed. The one exception is the first byte of a two-byte sequence: it is held in a one-entry stage until the next byte shows whether the sequence completes. Back-pressure follows three rules:
- A byte that is to be forwarded is accepted only when `out_ready` is high.
- A swallowed or captured byte is accepted whatever `out_ready` is.
- While a held byte is being released, the input is stalled.

A source holds `in_valid` and `in_data` until a byte is accepted.

The compare-mode bits must pass through the disabled setting (`00`) whenever they change between two enabled settings.

Top module: `xfd_rx_detect`

## Requirements
- R1: With `fc_rx_mode` = 2'b00, every input byte is forwarded unchanged, in order, and `tx_pause` never changes.
- R2: With `fc_rx_mode` = 2'b10, a byte equal to `xoff_a` is swallowed and sets `tx_pause` and `irq_xoff`. A byte equal to `xon_a` is swallowed and clears `tx_pause`. All other bytes are forwarded.
- R3: With `fc_rx_mode` = 2'b01, bytes equal to `xoff_b` or `xon_b` are swallowed. They set or clear `tx_pause` in the same way as in R2, and all other bytes (including `xoff_a`) are forwarded.
- R4: With `fc_rx_mode` = 2'b11, `xoff_a` immediately followed by `xoff_b` is swallowed as a pair and sets `tx_pause` and `irq_xoff`. `xon_a` followed by `xon_b` is swallowed and clears `tx_pause`.
- R5: In mode 2'b11, if the byte after a held first character does not complete its sequence, the held byte is forwarded first. The new byte is then evaluated from scratch and may itself start a new sequence.
- R6: With `spc_en` high, every accepted byte equal to `xoff_b` sets `irq_special`. Such a byte is still forwarded unless flow control swallows it.
- R7: In mode 2'b01 with `spc_en` high, a byte equal to `xoff_b` is not forwarded and raises both `irq_xoff` and `irq_special`.
- R8: `irq_xoff` and `irq_special` stay set until their one-cycle clear strobe (`clr_xoff`, `clr_special`). A new event in the same cycle as the strobe wins, and the flag stays set.
- R9: After reset, `tx_pause`, `irq_xoff`, `irq_special` and `out_valid` are low, and no byte is held.
- R10: While a byte is presented for forwarding and `out_ready` is low, `in_ready` is low and the byte is not consumed. Swallowed bytes are accepted even when `out_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fc_rx_mode | input | 2 | Receive compare mode: 00 off, 10 single A, 01 single B, 11 dual A-then-B |
| spc_en | input | 1 | Special-character detect enable |
| xon_a | input | 8 | First resume character |
| xon_b | input | 8 | Second resume character |
| xoff_a | input | 8 | First stop character |
| xoff_b | input | 8 | Second stop character, also the special character |
| in_valid | input | 1 | Received byte valid |
| in_ready | output | 1 | Received byte accepted this cycle |
| in_data | input | 8 | Received byte |
| out_valid | output | 1 | Byte offered to the FIFO |
| out_ready | input | 1 | FIFO can take a byte |
| out_data | output | 8 | Byte to the FIFO |
| tx_pause | output | 1 | Local transmitter must pause |
| irq_xoff | output | 1 | Sticky stop-sequence flag |
| irq_special | output | 1 | Sticky special-character flag |
| clr_xoff | input | 1 | One-cycle clear of `irq_xoff` |
| clr_special | input | 1 | One-cycle clear of `irq_special` |

## Verification
The same byte values are driven in each compare mode, so the scoreboard can tell which bytes are forwarded and which are swallowed. For example, `xoff_b` is forwarded in mode 10 and swallowed in mode 01. In dual mode, complete pairs are compared with broken pairs: a first character followed by an unrelated byte, and one followed by another first character. These separate a correct release of the held byte from a lost or reordered one. Back-pressure runs show that forwarded bytes wait for `out_ready` while swallowed bytes do not. A clear strobe issued together with a new event shows which one takes priority.

// File: rtl/xfd_pkg.sv
package xfd_pkg;
  typedef enum logic [1:0] {
    FC_OFF      = 2'b00,
    FC_SINGLE_B = 2'b01,
    FC_SINGLE_A = 2'b10,
    FC_DUAL     = 2'b11
  } rx_fc_e;

  typedef struct packed {
    logic xon_a;
    logic xon_b;
    logic xoff_a;
    logic xoff_b;
  } chr_hit_t;
endpackage

// File: rtl/xfd_char_cmp.sv
module xfd_char_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0]    chr,
  input  logic [W-1:0]    ref_xon_a,
  input  logic [W-1:0]    ref_xon_b,
  input  logic [W-1:0]    ref_xoff_a,
  input  logic [W-1:0]    ref_xoff_b,
  output xfd_pkg::chr_hit_t hit
);
  localparam int NREF = 4;

  logic [NREF-1:0][W-1:0] refs;
  logic [NREF-1:0]        eq;

  assign refs = {ref_xon_a, ref_xon_b, ref_xoff_a, ref_xoff_b};

  for (genvar i = 0; i < NREF; i++) begin : g_cmp
    assign eq[i] = (chr == refs[i]);
  end

  assign hit = xfd_pkg::chr_hit_t'(eq);
endmodule

// File: rtl/xfd_hold.sv
module xfd_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] cap_data,
  input  logic         cap_is_off,
  input  logic         drop,
  output logic         vld,
  output logic [W-1:0] data,
  output logic         is_off
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld    <= 1'b0;
      data   <= '0;
      is_off <= 1'b0;
    end else if (cap) begin
      vld    <= 1'b1;
      data   <= cap_data;
      is_off <= cap_is_off;
    end else if (drop) begin
      vld    <= 1'b0;
    end
  end

  // a byte is never captured while the previous one is still being dropped
  assert_cap_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap && vld));
endmodule

// File: rtl/xfd_status.sv
module xfd_status (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_off,
  input  logic ev_on,
  input  logic ev_spc,
  input  logic clr_off,
  input  logic clr_spc,
  output logic tx_pause,
  output logic irq_off,
  output logic irq_spc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_pause <= 1'b0;
      irq_off  <= 1'b0;
      irq_spc  <= 1'b0;
    end else begin
      if (ev_off)      tx_pause <= 1'b1;
      else if (ev_on)  tx_pause <= 1'b0;
      if (ev_off)      irq_off  <= 1'b1;
      else if (clr_off) irq_off <= 1'b0;
      if (ev_spc)      irq_spc  <= 1'b1;
      else if (clr_spc) irq_spc <= 1'b0;
    end
  end

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_off && !ev_off |=> !irq_off);
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_off && clr_off |=> irq_off);
  assert_special_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_spc |=> irq_spc);
  assert_resume_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_on && !ev_off |=> !tx_pause);
endmodule

// File: rtl/xfd_rx_detect.sv
module xfd_rx_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   fc_rx_mode,
  input  logic         spc_en,
  input  logic [W-1:0] xon_a,
  input  logic [W-1:0] xon_b,
  input  logic [W-1:0] xoff_a,
  input  logic [W-1:0] xoff_b,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         tx_pause,
  output logic         irq_xoff,
  output logic         irq_special,
  input  logic         clr_xoff,
  input  logic         clr_special
);
  import xfd_pkg::*;

  rx_fc_e   mode;
  chr_hit_t hit;
  logic         pend_vld, pend_off;
  logic [W-1:0] pend_data;
  logic complete, flush, begin_seq, swallow, off_sense, acc;
  logic cap, drop, ev_off, ev_on, ev_spc;

  assign mode = rx_fc_e'(fc_rx_mode);

  xfd_char_cmp #(.W(W)) u_cmp (
    .chr(in_data), .ref_xon_a(xon_a), .ref_xon_b(xon_b),
    .ref_xoff_a(xoff_a), .ref_xoff_b(xoff_b), .hit(hit)
  );

  // classification of the incoming byte
  always_comb begin
    complete  = pend_vld && (pend_off ? hit.xoff_b : hit.xon_b);
    flush     = pend_vld && in_valid && !complete;
    begin_seq = !pend_vld && (mode == FC_DUAL) && (hit.xoff_a || hit.xon_a);
    swallow   = !pend_vld &&
                (((mode == FC_SINGLE_A) && (hit.xon_a || hit.xoff_a)) ||
                 ((mode == FC_SINGLE_B) && (hit.xon_b || hit.xoff_b)));
    off_sense = (mode == FC_SINGLE_A) ? hit.xoff_a : hit.xoff_b;
  end

  // stream steering
  always_comb begin
    out_data = in_data;
    if (flush) begin
      out_valid = 1'b1;
      out_data  = pend_data;
      in_ready  = 1'b0;
    end else if (pend_vld || begin_seq || swallow) begin
      out_valid = 1'b0;
      in_ready  = 1'b1;
    end else begin
      out_valid = in_valid;
      in_ready  = out_ready;
    end
  end

  assign acc    = in_valid && in_ready;
  assign cap    = acc && begin_seq;
  assign drop   = (flush && out_ready) || (acc && complete);
  assign ev_off = acc && ((complete && pend_off) || (swallow && off_sense));
  assign ev_on  = acc && ((complete && !pend_off) || (swallow && !off_sense));
  assign ev_spc = acc && spc_en && hit.xoff_b;

  xfd_hold #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n), .cap(cap), .cap_data(in_data),
    .cap_is_off(hit.xoff_a), .drop(drop),
    .vld(pend_vld), .data(pend_data), .is_off(pend_off)
  );

  xfd_status u_status (
    .clk(clk), .rst_n(rst_n), .ev_off(ev_off), .ev_on(ev_on), .ev_spc(ev_spc),
    .clr_off(clr_xoff), .clr_spc(clr_special),
    .tx_pause(tx_pause), .irq_off(irq_xoff), .irq_spc(irq_special)
  );

  assert_off_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fc_rx_mode == 2'b00 && !pend_vld && in_valid |-> out_valid && out_data == in_data);
  assert_single_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && fc_rx_mode == 2'b10 && in_data == xoff_a |=> tx_pause);
  assert_swallow_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fc_rx_mode == 2'b01 && !pend_vld && in_valid && in_data == xoff_b |-> in_ready && !out_valid);
  assert_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_vld && out_valid && out_ready |=> !pend_vld);
  assert_backpressure_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

// File: tb/xfd_rx_detect_tb.sv
module xfd_rx_detect_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] XON_A = 8'h11, XOFF_A = 8'h13, XON_B = 8'h91, XOFF_B = 8'h93;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] fc_rx_mode = 2'b00;
  logic spc_en = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [7:0] in_data = '0;
  logic clr_xoff = 1'b0, clr_special = 1'b0;
  logic in_ready, out_valid, tx_pause, irq_xoff, irq_special;
  logic [7:0] out_data;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  xfd_rx_detect u_dut (
    .clk(clk), .rst_n(rst_n), .fc_rx_mode(fc_rx_mode), .spc_en(spc_en),
    .xon_a(XON_A), .xon_b(XON_B), .xoff_a(XOFF_A), .xoff_b(XOFF_B),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .tx_pause(tx_pause), .irq_xoff(irq_xoff), .irq_special(irq_special),
    .clr_xoff(clr_xoff), .clr_special(clr_special)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_out(input logic [7:0] b, input string req);
    exp_q.push_back(b);
    tag_q.push_back(req);
  endtask

  // driver: one byte through the handshake, returns one step after acceptance
  task automatic send(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    do @(negedge clk); while (!in_ready);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    fc_rx_mode = 2'b00;
    @(posedge clk); #1;
    fc_rx_mode = m;
  endtask

  task automatic pulse_clear();
    clr_xoff = 1'b1; clr_special = 1'b1;
    @(posedge clk); #1;
    clr_xoff = 1'b0; clr_special = 1'b0;
  endtask

  // monitor: a transfer happens at the next edge when both sides are high
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL unexpected output actual=%h expected=none", out_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, out_data, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 tx_pause", {7'd0, tx_pause}, 8'd0);
    check("R9 irq_xoff", {7'd0, irq_xoff}, 8'd0);
    check("R9 irq_special", {7'd0, irq_special}, 8'd0);
    check("R9 out_valid", {7'd0, out_valid}, 8'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: compare off, everything passes
    expect_out(8'h41, "R1"); send(8'h41);
    expect_out(XOFF_A, "R1"); send(XOFF_A);
    expect_out(XOFF_B, "R1"); send(XOFF_B);
    check("R1 tx_pause", {7'd0, tx_pause}, 8'd0);

    // R2: single A
    set_mode(2'b10);
    send(XOFF_A);
    check("R2 pause set", {7'd0, tx_pause}, 8'd1);
    check("R2 irq_xoff", {7'd0, irq_xoff}, 8'd1);
    expect_out(8'h43, "R2"); send(8'h43);
    expect_out(XOFF_B, "R2"); send(XOFF_B);
    check("R2 pause held", {7'd0, tx_pause}, 8'd1);
    send(XON_A);
    check("R2 pause cleared", {7'd0, tx_pause}, 8'd0);
    pulse_clear();
    check("R8 clear irq_xoff", {7'd0, irq_xoff}, 8'd0);

    // R6: special detect, forwarded in mode 10
    spc_en = 1'b1;
    expect_out(XOFF_B, "R6"); send(XOFF_B);
    check("R6 irq_special", {7'd0, irq_special}, 8'd1);
    check("R6 no pause", {7'd0, tx_pause}, 8'd0);
    pulse_clear();
    check("R8 clear irq_special", {7'd0, irq_special}, 8'd0);

    // R7 / R3: single B
    set_mode(2'b01);
    send(XOFF_B);
    check("R7 pause", {7'd0, tx_pause}, 8'd1);
    check("R7 irq_xoff", {7'd0, irq_xoff}, 8'd1);
    check("R7 irq_special", {7'd0, irq_special}, 8'd1);
    expect_out(XOFF_A, "R3"); send(XOFF_A);
    send(XON_B);
    check("R3 pause cleared", {7'd0, tx_pause}, 8'd0);
    spc_en = 1'b0;
    pulse_clear();

    // R4 / R5: dual
    set_mode(2'b11);
    send(XOFF_A); send(XOFF_B);
    check("R4 pause", {7'd0, tx_pause}, 8'd1);
    check("R4 irq_xoff", {7'd0, irq_xoff}, 8'd1);
    send(XON_A); send(XON_B);
    check("R4 resume", {7'd0, tx_pause}, 8'd0);
    expect_out(XOFF_A, "R5"); expect_out(8'h44, "R5");
    send(XOFF_A); send(8'h44);
    check("R5 no pause", {7'd0, tx_pause}, 8'd0);
    expect_out(XON_A, "R5");
    send(XON_A); send(XOFF_A); send(XOFF_B);
    check("R5 restart pause", {7'd0, tx_pause}, 8'd1);
    expect_out(XOFF_A, "R5"); expect_out(XON_B, "R5");
    send(XOFF_A); send(XON_B);
    check("R5 pause kept", {7'd0, tx_pause}, 8'd1);
    send(XON_A); send(XON_B);
    pulse_clear();

    // R10: back-pressure
    set_mode(2'b00);
    out_ready = 1'b0;
    in_valid = 1'b1; in_data = 8'h55;
    repeat (2) @(negedge clk);
    check("R10 in_ready low", {7'd0, in_ready}, 8'd0);
    check("R10 out_valid", {7'd0, out_valid}, 8'd1);
    expect_out(8'h55, "R10");
    @(posedge clk); #1;
    out_ready = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    set_mode(2'b10);
    out_ready = 1'b0;
    send(XOFF_A);
    check("R10 swallow under stall", {7'd0, tx_pause}, 8'd1);
    out_ready = 1'b1;
    send(XON_A);

    // R8: event beats clear
    clr_xoff = 1'b1;
    send(XOFF_A);
    clr_xoff = 1'b0;
    check("R8 set wins", {7'd0, irq_xoff}, 8'd1);

    repeat (3) @(posedge clk);
    #1;
    check("scoreboard drained", 8'(exp_q.size()), 8'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule